// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers sixteen level-sensitive interrupt inputs and drives one interrupt request line to a processor. Software fills a table with one handler address per source, assigns a priority level to each group of four consecutive sources, enables the sources it wants, and then turns the controller on. Raising the request line tells the processor that a source is pending that is enabled, sits in an enabled group level, and outranks the service already in progress.

The processor reaches its handler with a single register read. Reading the vector register returns the handler address of the winning source. The winner is the source with the highest level, and a tie within a level goes to the lowest-numbered source. If no source qualifies, the read returns a programmable default address. The same read marks the winner's level as active. While that level is active, every source at that level or below is held off. A source at a higher level can still raise the request, so services nest.

Writing the acknowledge register ends the innermost service. It drops the highest active level and brings back the floor that applied before that service began. A source whose input is still asserted when its level reopens requests service again at once.

Top module: `vec_intc`

## Requirements
- R1: After reset, the global enable, source enable, group levels, default vector, all handler entries and the active-level set are zero, the request output is low, and read data is zero.
- R2: The request output is high exactly when the global enable (bit 0 of register 0) is set and some source is asserted, enabled in register 1 (bit i for source i) and at a level above every active level; otherwise it is low.
- R3: A read of the vector register (word address 6) returns the handler entry of the winning source. Handler entry i sits at word address 0x20+i. The level of source i is the 2-bit field at bits [2g+1:2g] of register 4, where g = i/4. Level 3 is the highest. Ties go to the lowest source number.
- R4: A vector read with no eligible source returns the default address (register 5) and leaves the active-level set unchanged.
- R5: A vector read that finds a winner marks the winner's level active. From then on, sources at that level or lower do not raise the request.
- R6: During an active service, an eligible source at a higher level raises the request, and a vector read returns that source's handler entry.
- R7: Any write to the acknowledge register (word address 7) clears only the highest active level. A write to it when no level is active changes nothing.
- R8: A source still asserted when its level reopens raises the request again in the same cycle that the acknowledge takes effect.
- R9: Register 2 reads the raw input levels regardless of any enable. Register 3 reads raw AND source-enable. The enable, level, default and handler registers read back what was written.
- R10: Writes to read-only addresses (2, 3, 6) change nothing. When a read and a write arrive in the same cycle, the write is performed and read data keeps its previous value. A read takes effect at the clock edge, and read data is valid after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 6 | Word address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, registered |
| srcIrq | input | 16 | Level-sensitive interrupt inputs |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that the bus presents at most one access per cycle and that acknowledge writes follow only claimed services. They also assume the interrupt inputs stay steady across the edge that performs a vector read. The bench changes the inputs and the bus strobes only on falling edges, and it always acknowledges after a vector read has claimed a level. It exercises the empty-stack acknowledge on purpose, which the design must absorb without change.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;

  localparam int OFS_CTRL  = 0;
  localparam int OFS_SRCEN = 1;
  localparam int OFS_RAW   = 2;
  localparam int OFS_PEND  = 3;
  localparam int OFS_GRPLV = 4;
  localparam int OFS_DFLT  = 5;
  localparam int OFS_VECT  = 6;
  localparam int OFS_ACK   = 7;

  typedef enum logic [3:0] {
    RS_NONE, RS_CTRL, RS_EN, RS_RAW, RS_PEND, RS_LVL, RS_DFLT, RS_VEC, RS_TBL
  } rdSel_e;

  typedef struct packed {
    logic   wrCtrl;
    logic   wrEnable;
    logic   wrLevel;
    logic   wrDefault;
    logic   wrTable;
    logic   claim;
    logic   ack;
    logic   rdLoad;
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/vec_intc_ctrl.sv
module vec_intc_ctrl
  import vec_intc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int AW      = 6,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [AW-1:0]    regAddr,
  output strobes_t         stb,
  output logic [SRC_W-1:0] tblIdx
);

  logic tblHit;

  assign tblHit = regAddr[AW-1] && (int'(regAddr[AW-2:0]) < NUM_SRC);
  assign tblIdx = regAddr[SRC_W-1:0];

  always_comb begin
    stb = '0;
    stb.rdSel = RS_NONE;
    if (regWr) begin
      stb.wrCtrl    = (regAddr == AW'(OFS_CTRL));
      stb.wrEnable  = (regAddr == AW'(OFS_SRCEN));
      stb.wrLevel   = (regAddr == AW'(OFS_GRPLV));
      stb.wrDefault = (regAddr == AW'(OFS_DFLT));
      stb.ack       = (regAddr == AW'(OFS_ACK));
      stb.wrTable   = tblHit;
    end else if (regRd) begin
      stb.rdLoad = 1'b1;
      if (tblHit) stb.rdSel = RS_TBL;
      else begin
        case (regAddr)
          AW'(OFS_CTRL):  stb.rdSel = RS_CTRL;
          AW'(OFS_SRCEN): stb.rdSel = RS_EN;
          AW'(OFS_RAW):   stb.rdSel = RS_RAW;
          AW'(OFS_PEND):  stb.rdSel = RS_PEND;
          AW'(OFS_GRPLV): stb.rdSel = RS_LVL;
          AW'(OFS_DFLT):  stb.rdSel = RS_DFLT;
          AW'(OFS_VECT):  stb.rdSel = RS_VEC;
          default:        stb.rdSel = RS_NONE;
        endcase
      end
      stb.claim = (regAddr == AW'(OFS_VECT));
    end
  end

  // R10
  wr_beats_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWr |-> (!stb.rdLoad && !stb.claim));

  // R7
  claim_ack_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.claim && stb.ack));

endmodule

// File: rtl/vec_intc_dp.sv
module vec_intc_dp
  import vec_intc_pkg::*;
#(
  parameter int NUM_SRC    = 16,
  parameter int GROUP_SIZE = 4,
  parameter int NUM_LVL    = 4,
  parameter int DATA_W     = 32,
  localparam int SRC_W     = $clog2(NUM_SRC),
  localparam int LVL_W     = $clog2(NUM_LVL),
  localparam int NUM_GRP   = NUM_SRC / GROUP_SIZE,
  localparam int LVLREG_W  = NUM_GRP * LVL_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           stb,
  input  logic [SRC_W-1:0]   tblIdx,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic [NUM_SRC-1:0] srcIrq,
  output logic [DATA_W-1:0]  regRdata,
  output logic               irqOut
);

  logic                ctrlEn;
  logic [NUM_SRC-1:0]  srcEn;
  logic [LVLREG_W-1:0] grpLvl;
  logic [DATA_W-1:0]   dfltVec;
  logic [DATA_W-1:0]   vecTbl [NUM_SRC];
  logic [NUM_LVL-1:0]  activeLv;

  logic [LVL_W-1:0]    srcLvl [NUM_SRC];
  logic [NUM_LVL-1:0]  lvlOpen;
  logic [NUM_SRC-1:0]  eligible;
  logic                winValid;
  logic [SRC_W-1:0]    winIdx;
  logic [LVL_W-1:0]    winLvl;
  logic [NUM_LVL-1:0]  topMask;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_open
    assign lvlOpen[l] = ~|activeLv[NUM_LVL-1:l];
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign srcLvl[i]   = grpLvl[(i / GROUP_SIZE) * LVL_W +: LVL_W];
    assign eligible[i] = ctrlEn & srcIrq[i] & srcEn[i] & lvlOpen[srcLvl[i]];
  end

  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    winLvl   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eligible[i] && (!winValid || srcLvl[i] > winLvl)) begin
        winValid = 1'b1;
        winIdx   = SRC_W'(i);
        winLvl   = srcLvl[i];
      end
    end
  end

  always_comb begin
    topMask = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (activeLv[l]) begin
        topMask    = '0;
        topMask[l] = 1'b1;
      end
    end
  end

  assign irqOut = winValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn   <= 1'b0;
      srcEn    <= '0;
      grpLvl   <= '0;
      dfltVec  <= '0;
      activeLv <= '0;
      regRdata <= '0;
      for (int i = 0; i < NUM_SRC; i++) vecTbl[i] <= '0;
    end else begin
      if (stb.wrCtrl)    ctrlEn  <= regWdata[0];
      if (stb.wrEnable)  srcEn   <= regWdata[NUM_SRC-1:0];
      if (stb.wrLevel)   grpLvl  <= regWdata[LVLREG_W-1:0];
      if (stb.wrDefault) dfltVec <= regWdata;
      if (stb.wrTable)   vecTbl[tblIdx] <= regWdata;

      if (stb.claim && winValid) activeLv[winLvl] <= 1'b1;
      else if (stb.ack)          activeLv <= activeLv & ~topMask;

      if (stb.rdLoad) begin
        case (stb.rdSel)
          RS_CTRL: regRdata <= DATA_W'(ctrlEn);
          RS_EN:   regRdata <= DATA_W'(srcEn);
          RS_RAW:  regRdata <= DATA_W'(srcIrq);
          RS_PEND: regRdata <= DATA_W'(srcIrq & srcEn);
          RS_LVL:  regRdata <= DATA_W'(grpLvl);
          RS_DFLT: regRdata <= dfltVec;
          RS_VEC:  regRdata <= winValid ? vecTbl[winIdx] : dfltVec;
          RS_TBL:  regRdata <= vecTbl[tblIdx];
          default: regRdata <= '0;
        endcase
      end
    end
  end

  // R2
  irq_needs_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (ctrlEn && (|(srcIrq & srcEn))));

  // R5
  claim_raises_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.claim && winValid) |=> activeLv[$past(winLvl)]);

  // R4
  empty_claim_keeps_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.claim && !winValid) |=> $stable(activeLv));

  // R7
  ack_pops_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ack && (|activeLv)) |=>
      ($countones(activeLv) == $countones($past(activeLv)) - 1));

  // R7
  ack_empty_noop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ack && !(|activeLv)) |=> (activeLv == '0));

endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vec_intc_pkg::*;
#(
  parameter int NUM_SRC    = 16,
  parameter int GROUP_SIZE = 4,
  parameter int NUM_LVL    = 4,
  parameter int DATA_W     = 32,
  parameter int AW         = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic               regRd,
  input  logic [AW-1:0]      regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic [NUM_SRC-1:0] srcIrq,
  output logic               irqOut
);

  localparam int SRC_W = $clog2(NUM_SRC);

  strobes_t         stb;
  logic [SRC_W-1:0] tblIdx;

  vec_intc_ctrl #(.NUM_SRC(NUM_SRC), .AW(AW)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWr   (regWr),
    .regRd   (regRd),
    .regAddr (regAddr),
    .stb     (stb),
    .tblIdx  (tblIdx)
  );

  vec_intc_dp #(
    .NUM_SRC(NUM_SRC), .GROUP_SIZE(GROUP_SIZE),
    .NUM_LVL(NUM_LVL), .DATA_W(DATA_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .tblIdx   (tblIdx),
    .regWdata (regWdata),
    .srcIrq   (srcIrq),
    .regRdata (regRdata),
    .irqOut   (irqOut)
  );

endmodule

// File: tb/test_vec_intc.sv
module test_vec_intc;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [15:0] srcIrq = '0;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  vec_intc i_vec_intc (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .srcIrq(srcIrq), .irqOut(irqOut)
  );

  localparam logic [31:0] DFLT = 32'hDEAD_0000;

  function automatic logic [31:0] tblVal(int i);
    return 32'h1000 + 32'(i) * 32'h40;
  endfunction

  function automatic int lvlOf(int i, logic [7:0] cfg);
    return int'((cfg >> (2 * (i / 4))) & 8'h3);
  endfunction

  // index of expected winner, -1 if none
  function automatic int model(logic [15:0] pend, logic [7:0] cfg, logic [3:0] act);
    int best = -1;
    int bl = -1;
    for (int i = 0; i < 16; i++) begin
      int l = lvlOf(i, cfg);
      if (pend[i] && ((act >> l) == 4'h0) && l > bl) begin
        best = i;
        bl = l;
      end
    end
    return best;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regRd = 1'b0; regAddr = 6'(a); regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    regRd = 1'b1; regWr = 1'b0; regAddr = 6'(a);
    @(negedge clk);
    regRd = 1'b0;
    d = regRdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] prev;
    logic [7:0]  cfgs [3];
    int          e;
    cfgs[0] = 8'h1B; cfgs[1] = 8'hE4; cfgs[2] = 8'h00;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(irqOut == 1'b0, "R1 irq", 32'(irqOut), 0);
    chk(regRdata == 0, "R1 rdata", regRdata, 0);
    rd(0, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(1, d); chk(d == 0, "R1 srcen", d, 0);
    rd(4, d); chk(d == 0, "R1 grplvl", d, 0);
    rd(5, d); chk(d == 0, "R1 default", d, 0);
    rd(32 + 7, d); chk(d == 0, "R1 table", d, 0);
    rd(6, d); chk(d == 0, "R1/R4 vector while off", d, 0);

    // programming
    for (int i = 0; i < 16; i++) wr(32 + i, tblVal(i));
    wr(5, DFLT);
    wr(4, 32'(cfgs[0]));
    rd(32 + 5, d); chk(d == tblVal(5), "R9 table readback", d, tblVal(5));
    rd(4, d); chk(d == 32'h1B, "R9 level readback", d, 32'h1B);

    // R9 status registers
    wr(1, 32'h0F0F);
    srcIrq = 16'hA5A5;
    rd(2, d); chk(d == 32'hA5A5, "R9 raw", d, 32'hA5A5);
    rd(3, d); chk(d == 32'h0505, "R9 pending", d, 32'h0505);
    rd(1, d); chk(d == 32'h0F0F, "R9 enable", d, 32'h0F0F);

    // R2 global enable off blocks request
    @(negedge clk);
    chk(irqOut == 1'b0, "R2 ctrl off", 32'(irqOut), 0);

    // R10 write to read-only addresses ignored
    wr(2, 32'hFFFF_FFFF);
    wr(3, 32'hFFFF_FFFF);
    rd(2, d); chk(d == 32'hA5A5, "R10 raw write ignored", d, 32'hA5A5);
    rd(1, d); chk(d == 32'h0F0F, "R10 enable untouched", d, 32'h0F0F);

    // R10 read and write together: write happens, read data holds
    prev = regRdata;
    @(negedge clk);
    regWr = 1'b1; regRd = 1'b1; regAddr = 6'd1; regWdata = 32'hFFFF;
    @(negedge clk);
    regWr = 1'b0; regRd = 1'b0;
    chk(regRdata == prev, "R10 read held", regRdata, prev);
    rd(1, d); chk(d == 32'hFFFF, "R10 write done", d, 32'hFFFF);

    wr(0, 1);
    srcIrq = '0;
    @(negedge clk);
    chk(irqOut == 1'b0, "R2 idle", 32'(irqOut), 0);

    // R2 source enable bit gates the request
    wr(1, 32'hFFF7);
    srcIrq = 16'h0008;
    @(negedge clk);
    chk(irqOut == 1'b0, "R2 source disabled", 32'(irqOut), 0);
    wr(1, 32'hFFFF);
    @(negedge clk);
    chk(irqOut == 1'b1, "R2 source enabled", 32'(irqOut), 1);
    srcIrq = '0;

    // pair sweep over three level configurations
    for (int c = 0; c < 3; c++) begin
      wr(4, 32'(cfgs[c]));
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 16; j++) begin
          srcIrq = (16'h1 << i) | (16'h1 << j);
          @(negedge clk);
          e = model(srcIrq, cfgs[c], 4'h0);
          chk(irqOut == 1'b1, "R2 pending pair", 32'(irqOut), 1);
          rd(6, d);
          chk(d == tblVal(e), "R3 vector winner", d, tblVal(e));
          chk(irqOut == 1'b0, "R5 floor masks pair", 32'(irqOut), 0);
          wr(7, 0);
          chk(irqOut == 1'b1, "R8 still asserted", 32'(irqOut), 1);
          srcIrq = '0;
        end
      end
    end

    // nesting, levels: src0-3=3, 4-7=2, 8-11=1, 12-15=0
    wr(4, 32'h1B);
    srcIrq = 16'h0200;
    rd(6, d); chk(d == tblVal(9), "R3 claim src9", d, tblVal(9));
    chk(irqOut == 1'b0, "R5 masked own", 32'(irqOut), 0);
    srcIrq = 16'h2200;
    @(negedge clk);
    chk(irqOut == 1'b0, "R5 lower masked", 32'(irqOut), 0);
    srcIrq = 16'h2220;
    @(negedge clk);
    chk(irqOut == 1'b1, "R6 higher preempts", 32'(irqOut), 1);
    rd(6, d); chk(d == tblVal(5), "R6 nested vector", d, tblVal(5));
    chk(irqOut == 1'b0, "R5 nested masked", 32'(irqOut), 0);
    srcIrq = 16'h2200;
    wr(7, 0);
    chk(irqOut == 1'b0, "R7 previous floor restored", 32'(irqOut), 0);
    wr(7, 0);
    chk(irqOut == 1'b1, "R7 floor cleared", 32'(irqOut), 1);
    rd(6, d); chk(d == tblVal(9), "R8 reasserted src9", d, tblVal(9));
    wr(7, 0);
    srcIrq = 16'h2000;
    rd(6, d); chk(d == tblVal(13), "R3 low level", d, tblVal(13));
    wr(7, 0);
    wr(7, 0);
    chk(irqOut == 1'b1, "R7 empty ack noop", 32'(irqOut), 1);
    rd(6, d); chk(d == tblVal(13), "R7 empty ack vector", d, tblVal(13));
    wr(7, 0);

    // R4 default vector and unchanged floor
    srcIrq = '0;
    rd(6, d); chk(d == DFLT, "R4 default vector", d, DFLT);
    srcIrq = 16'h1000;
    @(negedge clk);
    chk(irqOut == 1'b1, "R4 floor untouched", 32'(irqOut), 1);
    srcIrq = '0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule